// File: doc/BRIEF.md
# Local Exclusive Reservation Monitor

This block keeps the exclusive-access reservation for a single processor port. It is one half of a check that is made in two parts. It sees every memory access the port issues, described by a kind, an address and a transaction size. A load-exclusive sets up a reservation. The block then watches for anything that breaks that reservation before the matching store-exclusive arrives. For each store-exclusive it gives a local verdict. A pass only means the local side allows the store. Whether memory is actually written also depends on a system-wide check that lives elsewhere. The block moves no data and knows nothing about other processors.

The rules are deliberately strict:

- Any plain load or plain store seen while a reservation is held drops it, whatever its address.
- A store-exclusive succeeds only when both its address and its size match the reservation exactly. No low address bits are ignored.
- Every store-exclusive closes the reservation, whether it passes or fails.
- A synchronous flush input drops the reservation at once, for example on an exception entry or a context switch.

Each access is qualified by a valid strobe. The verdict is registered and appears one cycle after the store-exclusive is presented.

Top module: `excl_monitor`

## Requirements
- R1: After reset the monitor holds no reservation. The recorded tag is address zero with size None, and verdictValid and verdictFail are both 0. A reservation held before reset is lost.
- R2: A valid load-exclusive (accKind = 2'b01) always takes a reservation and records its address and size. It replaces any reservation taken earlier. Size codes on accSize are None = 0, Byte = 1, HalfWord = 2, Word = 4.
- R3: A valid plain load (2'b00) or plain store (2'b10) seen while a reservation is held drops the reservation, whatever its address or size.
- R4: A valid store-exclusive (2'b11) passes only when three things hold: a reservation is held, accAddr equals the recorded address in every bit, and accSize equals the recorded size.
- R5: Every store-exclusive seen while a reservation is held drops the reservation, whether it passes or fails.
- R6: A store-exclusive seen while no reservation is held fails and leaves the monitor without a reservation.
- R7: verdictValid is 1 for exactly the one cycle after a valid store-exclusive, and only then. In that cycle verdictFail is 0 for pass and 1 for fail. Plain accesses and load-exclusives produce no verdict.
- R8: flushReq drops any reservation and takes priority over an access in the same cycle. A load-exclusive presented with flushReq takes no reservation. A store-exclusive presented with flushReq fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| flushReq | input | 1 | Synchronous drop of the reservation |
| accValid | input | 1 | Qualifies the access fields this cycle |
| accKind | input | 2 | 00 load, 01 load-exclusive, 10 store, 11 store-exclusive |
| accAddr | input | ADDR_W | Byte address of the access |
| accSize | input | 3 | Transaction size code: 0 None, 1 Byte, 2 HalfWord, 4 Word |
| verdictValid | output | 1 | A store-exclusive verdict is present this cycle |
| verdictFail | output | 1 | Store-exclusive status: 0 pass, 1 fail |

## Verification
The main stream of accesses pairs a load-exclusive with a store-exclusive and varies what comes between them. Sometimes nothing comes between them; other patterns insert a plain load or store at an unrelated address, or a second load-exclusive elsewhere. Some pairs differ only in size, others in the lowest address bit. These patterns separate an exact comparison from a masked one, and a size-aware check from an address-only one. They also tell an unconditional drop on plain traffic apart from an address-filtered drop. Back-to-back store-exclusives show that a pass also closes the reservation. Directed cases cover reset during a reservation and flush on an idle cycle. They also present a flush in the same cycle as each of the two exclusive kinds, which pins down its priority.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;

  localparam int KIND_W = 2;
  localparam int SIZE_W = 3;

  typedef enum logic [KIND_W-1:0] {
    KIND_LOAD      = 2'b00,
    KIND_LOAD_EXCL = 2'b01,
    KIND_STORE     = 2'b10,
    KIND_STORE_EXCL = 2'b11
  } accKind_e;

  typedef enum logic [SIZE_W-1:0] {
    SIZE_NONE = 3'd0,
    SIZE_BYTE = 3'd1,
    SIZE_HALF = 3'd2,
    SIZE_WORD = 3'd4
  } accSize_e;

  typedef enum logic {
    MON_OPEN = 1'b0,
    MON_EXCL = 1'b1
  } monState_e;

  // Strobes from the control FSM to the tag datapath.
  typedef struct packed {
    logic arm;    // capture address and size of a load-exclusive
    logic clear;  // return the tag to address zero, size None
  } monStrobe_t;

endpackage

// File: rtl/excl_tag_path.sv
module excl_tag_path
  import excl_mon_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  monStrobe_t        strobes,
  input  logic [ADDR_W-1:0] accAddr,
  input  accSize_e          accSize,
  output logic              addrHit,
  output logic              sizeHit
);

  logic [ADDR_W-1:0] tagAddr;
  accSize_e          tagSize;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tagAddr <= '0;
      tagSize <= SIZE_NONE;
    end else if (strobes.clear) begin
      tagAddr <= '0;
      tagSize <= SIZE_NONE;
    end else if (strobes.arm) begin
      tagAddr <= accAddr;
      tagSize <= accSize;
    end
  end

  // Exact comparison over every address bit, no granule masking.
  assign addrHit = (accAddr == tagAddr);
  assign sizeHit = (accSize == tagSize);

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.arm, strobes.clear})) else $error("arm and clear together"); // R8

  AST_ARM_RECORDS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.arm |=> (tagAddr == $past(accAddr)) && (tagSize == $past(accSize)))
    else $error("tag not recorded"); // R2

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clear |=> (tagAddr == '0) && (tagSize == SIZE_NONE))
    else $error("tag not cleared"); // R1

endmodule

// File: rtl/excl_mon_ctrl.sv
module excl_mon_ctrl
  import excl_mon_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       flushReq,
  input  logic       accValid,
  input  accKind_e   accKind,
  input  logic       addrHit,
  input  logic       sizeHit,
  output monStrobe_t strobes,
  output logic       verdictValid,
  output logic       verdictFail
);

  monState_e stateQ;
  monState_e stateD;
  logic      isStoreExcl;
  logic      isLoadExcl;
  logic      acceptNow;
  logic      passNow;

  assign acceptNow   = accValid && !flushReq;
  assign isStoreExcl = accValid && (accKind == KIND_STORE_EXCL);
  assign isLoadExcl  = accValid && (accKind == KIND_LOAD_EXCL);
  assign passNow     = acceptNow && isStoreExcl && (stateQ == MON_EXCL)
                       && addrHit && sizeHit;

  always_comb begin
    stateD = stateQ;
    if (flushReq) begin
      stateD = MON_OPEN;
    end else if (accValid) begin
      if (accKind == KIND_LOAD_EXCL) stateD = MON_EXCL;
      else                           stateD = MON_OPEN;
    end
  end

  always_comb begin
    strobes.arm   = acceptNow && isLoadExcl;
    strobes.clear = flushReq
                    || (accValid && !isLoadExcl && (stateQ == MON_EXCL));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ       <= MON_OPEN;
      verdictValid <= 1'b0;
      verdictFail  <= 1'b0;
    end else begin
      stateQ       <= stateD;
      verdictValid <= isStoreExcl;
      verdictFail  <= isStoreExcl && !passNow;
    end
  end

  AST_LOAD_EXCL_ARMS: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accKind == KIND_LOAD_EXCL && !flushReq) |=> stateQ == MON_EXCL)
    else $error("load-exclusive did not arm"); // R2

  AST_PLAIN_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && (accKind == KIND_LOAD || accKind == KIND_STORE)) |=> stateQ == MON_OPEN)
    else $error("plain access kept reservation"); // R3

  AST_PASS_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (verdictValid && !verdictFail) |-> $past(addrHit && sizeHit && stateQ == MON_EXCL))
    else $error("pass without match"); // R4

  AST_STORE_EXCL_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accKind == KIND_STORE_EXCL) |=> stateQ == MON_OPEN)
    else $error("store-exclusive kept reservation"); // R5

  AST_OPEN_STEX_FAILS: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accKind == KIND_STORE_EXCL && stateQ == MON_OPEN) |=> verdictValid && verdictFail)
    else $error("store-exclusive passed while open"); // R6

  AST_VERDICT_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    verdictValid |-> $past(accValid && accKind == KIND_STORE_EXCL))
    else $error("spurious verdict"); // R7

  AST_FAIL_QUALIFIED: assert property (@(posedge clk) disable iff (!rstN)
    verdictFail |-> verdictValid)
    else $error("fail without verdict"); // R7

  AST_FLUSH_WINS: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |=> (stateQ == MON_OPEN) && (!verdictValid || verdictFail))
    else $error("flush did not win"); // R8

endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
  import excl_mon_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flushReq,
  input  logic              accValid,
  input  logic [1:0]        accKind,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [2:0]        accSize,
  output logic              verdictValid,
  output logic              verdictFail
);

  monStrobe_t strobes;
  logic       addrHit;
  logic       sizeHit;

  excl_mon_ctrl uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .flushReq     (flushReq),
    .accValid     (accValid),
    .accKind      (accKind_e'(accKind)),
    .addrHit      (addrHit),
    .sizeHit      (sizeHit),
    .strobes      (strobes),
    .verdictValid (verdictValid),
    .verdictFail  (verdictFail)
  );

  excl_tag_path #(.ADDR_W(ADDR_W)) uPath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .accAddr (accAddr),
    .accSize (accSize_e'(accSize)),
    .addrHit (addrHit),
    .sizeHit (sizeHit)
  );

endmodule

// File: tb/tb_excl_monitor.sv
module tb_excl_monitor;

  localparam int CLK_PERIOD = 10;
  localparam int N_VEC = 22;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        flushReq = 1'b0;
  logic        accValid = 1'b0;
  logic [1:0]  accKind = 2'b00;
  logic [31:0] accAddr = '0;
  logic [2:0]  accSize = '0;
  logic        verdictValid;
  logic        verdictFail;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  excl_monitor #(.ADDR_W(32)) dut (
    .clk(clk), .rstN(rstN), .flushReq(flushReq), .accValid(accValid),
    .accKind(accKind), .accAddr(accAddr), .accSize(accSize),
    .verdictValid(verdictValid), .verdictFail(verdictFail)
  );

  // kind, address, size, expected verdictValid, expected verdictFail
  // kind: 0 load, 1 load-excl, 2 store, 3 store-excl; size: 1 B, 2 H, 4 W
  localparam logic [38:0] VEC [N_VEC] = '{
    {2'd3, 32'h0000_0100, 3'd4, 1'b1, 1'b1},  //  0 R6 open store-excl fails
    {2'd1, 32'h0000_0100, 3'd4, 1'b0, 1'b0},  //  1
    {2'd3, 32'h0000_0100, 3'd4, 1'b1, 1'b0},  //  2 R4 match passes
    {2'd3, 32'h0000_0100, 3'd4, 1'b1, 1'b1},  //  3 R5 pass closed it
    {2'd1, 32'h0000_0200, 3'd2, 1'b0, 1'b0},  //  4
    {2'd3, 32'h0000_0200, 3'd4, 1'b1, 1'b1},  //  5 R4 size differs
    {2'd3, 32'h0000_0200, 3'd2, 1'b1, 1'b1},  //  6 R5 fail closed it
    {2'd1, 32'h0000_0300, 3'd1, 1'b0, 1'b0},  //  7
    {2'd3, 32'h0000_0301, 3'd1, 1'b1, 1'b1},  //  8 R4 low bit differs
    {2'd1, 32'h0000_0300, 3'd4, 1'b0, 1'b0},  //  9
    {2'd0, 32'h0000_9990, 3'd4, 1'b0, 1'b0},  // 10 R3 unrelated load
    {2'd3, 32'h0000_0300, 3'd4, 1'b1, 1'b1},  // 11 R3
    {2'd1, 32'h0000_0400, 3'd4, 1'b0, 1'b0},  // 12
    {2'd2, 32'h0000_8000, 3'd1, 1'b0, 1'b0},  // 13 R3 unrelated store
    {2'd3, 32'h0000_0400, 3'd4, 1'b1, 1'b1},  // 14 R3
    {2'd1, 32'h0000_0500, 3'd4, 1'b0, 1'b0},  // 15
    {2'd1, 32'h0000_0600, 3'd2, 1'b0, 1'b0},  // 16 R2 re-arm elsewhere
    {2'd3, 32'h0000_0500, 3'd4, 1'b1, 1'b1},  // 17 R2 old tag gone
    {2'd1, 32'h0000_0600, 3'd2, 1'b0, 1'b0},  // 18
    {2'd3, 32'h0000_0600, 3'd2, 1'b1, 1'b0},  // 19 R2 new tag passes
    {2'd1, 32'hFFFF_FFFC, 3'd4, 1'b0, 1'b0},  // 20
    {2'd3, 32'hFFFF_FFFC, 3'd4, 1'b1, 1'b0}   // 21 R4 top of address space
  };

  function automatic string reqOf(int idx);
    case (idx)
      0:                 return "R6";
      3, 6:              return "R5";
      10, 11, 13, 14:    return "R3";
      16, 17, 18, 19:    return "R2";
      default:           return "R4/R7";
    endcase
  endfunction

  task automatic check(string req, string what, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual valid/fail=%b expected=%b", req, what, act, exp);
    end
  endtask

  // Called at a negedge; returns at the next negedge with the verdict visible.
  task automatic issue(logic [1:0] k, logic [31:0] a, logic [2:0] s, logic fl);
    accValid = 1'b1;
    accKind  = k;
    accAddr  = a;
    accSize  = s;
    flushReq = fl;
    @(negedge clk);
    accValid = 1'b0;
    flushReq = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R7 watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state of the outputs
    check("R1", "outputs in reset", {verdictValid, verdictFail}, 2'b00);
    rstN = 1'b1;
    idle();
    check("R1", "outputs after reset", {verdictValid, verdictFail}, 2'b00);
    // R1: cleared tag (address 0, size None) is not a reservation
    issue(2'd3, 32'h0, 3'd0, 1'b0);
    check("R1", "store-excl to zero tag after reset", {verdictValid, verdictFail}, 2'b11);

    for (int i = 0; i < N_VEC; i++) begin
      issue(VEC[i][38:37], VEC[i][36:5], VEC[i][4:2], 1'b0);
      check(reqOf(i), $sformatf("vector %0d", i), {verdictValid, verdictFail}, VEC[i][1:0]);
    end

    // R7: verdict lasts one cycle only
    issue(2'd1, 32'h0000_0700, 3'd4, 1'b0);
    issue(2'd3, 32'h0000_0700, 3'd4, 1'b0);
    check("R7", "pass status is 0", {verdictValid, verdictFail}, 2'b10);
    idle();
    check("R7", "verdict gone next cycle", {verdictValid, verdictFail}, 2'b00);

    // R1: reset drops a held reservation
    issue(2'd1, 32'h0000_0040, 3'd4, 1'b0);
    rstN = 1'b0;
    idle();
    idle();
    rstN = 1'b1;
    issue(2'd3, 32'h0000_0040, 3'd4, 1'b0);
    check("R1", "reservation lost over reset", {verdictValid, verdictFail}, 2'b11);

    // R8: flush on an idle cycle
    issue(2'd1, 32'h0000_0080, 3'd2, 1'b0);
    flushReq = 1'b1;
    idle();
    flushReq = 1'b0;
    issue(2'd3, 32'h0000_0080, 3'd2, 1'b0);
    check("R8", "idle flush drops reservation", {verdictValid, verdictFail}, 2'b11);

    // R8: flush with a load-exclusive takes no reservation
    issue(2'd1, 32'h0000_0090, 3'd4, 1'b1);
    issue(2'd3, 32'h0000_0090, 3'd4, 1'b0);
    check("R8", "load-excl with flush does not arm", {verdictValid, verdictFail}, 2'b11);

    // R8: flush with a matching store-exclusive forces failure
    issue(2'd1, 32'h0000_00A0, 3'd1, 1'b0);
    issue(2'd3, 32'h0000_00A0, 3'd1, 1'b1);
    check("R8", "store-excl with flush fails", {verdictValid, verdictFail}, 2'b11);

    // R8: monitor works normally after a flush
    issue(2'd1, 32'h0000_00B0, 3'd1, 1'b0);
    issue(2'd3, 32'h0000_00B0, 3'd1, 1'b0);
    check("R8", "arm after flush passes", {verdictValid, verdictFail}, 2'b10);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule